// File: doc/BRIEF.md
# Page-Segmenting Message DMA Engine

This engine moves long messages between user virtual buffers and a packet network. On the outbound side it takes one message descriptor (identifier, virtual start address, byte length), cuts the message so that no segment crosses a page boundary, and translates each segment's virtual page through a shared lookup port. Each segment leaves as one header-plus-address record toward the send FIFO. The first segment is shortened so that every later segment starts on a page boundary.

On the inbound side it accepts segment headers in order. The first segment of a message carries the destination buffer's virtual base address. Segments are written into that buffer piece by piece, and a piece is split again wherever the destination crosses a page, with one translation per piece. After the final segment it posts a completion record. A three-way dispatcher shares the single translation port and the single action slot per cycle among receive work, send work and completion posting. A receive FIFO that is nearly full jumps the queue, and send work only asks for service while the send FIFO has room, so inbound data keeps draining while outbound traffic is stalled.

A translation miss aborts only the affected message and reports it with an error flag.

Top module: `msd_top`

## Requirements
- R1: After reset, `seg_valid`, `wr_valid` and `done_valid` are low and both `snd_ready` and `rx_ready` are high.
- R2: A send of length L at virtual address A yields segments with `seg_idx` counting 0,1,2,… and the accepted `seg_id`. The first segment has length min(L, PAGE − A mod PAGE), each later one min(remaining, PAGE), and `seg_last` is 1 only on the final segment.
- R3: Each segment's `seg_paddr` is the physical page returned for that segment's virtual page (upper bits), followed by the unchanged in-page offset (low PAGE_BITS bits).
- R4: After the final segment a completion pulses with `done_rx`=0, `done_id` = message id and `done_err`=0. A zero-length send produces no segment and only this completion.
- R5: If a send page misses in translation, no segment is issued for it or any later page, and a completion with `done_rx`=0 and `done_err`=1 follows.
- R6: Received data is written as pieces, each starting at the running destination address (the base from the segment with `rx_idx`=0, advanced by every byte placed). Each piece is cut at destination page boundaries and at segment ends, and `wr_paddr` is the translated page followed by the offset.
- R7: After the last piece of the segment flagged `rx_last`, a completion pulses with `done_rx`=1, the message id and `done_err`=0.
- R8: A receive translation miss drops the rest of that message, with no further writes. Its completion carries `done_err`=1 and is issued once the segment flagged `rx_last` has been taken. The next message is placed normally.
- R9: While `seg_ready` is low, no segment is issued, yet received segments are still written and completed.
- R10: While `rx_near_full` is high, a held receive segment is served every cycle until it is consumed, even with send work pending.
- R11: At most one of `seg_valid`, `wr_valid`, `done_valid` is high in any cycle.
- R12: `snd_ready` stays low from acceptance of a send until its completion has been posted.
- R13: With `rx_near_full` low and both receive and send work pending, grants rotate, so consecutive pieces of one receive segment are two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| snd_valid | input | 1 | Send descriptor present |
| snd_ready | output | 1 | Send descriptor accepted this cycle when high |
| snd_id | input | ID_W | Message identifier |
| snd_va | input | VA_W | Source virtual start address |
| snd_len | input | LEN_W | Message byte length |
| seg_ready | input | 1 | Send FIFO has room |
| seg_valid | output | 1 | Segment record pulse |
| seg_id | output | ID_W | Segment's message id |
| seg_idx | output | IDX_W | Segment index within message |
| seg_len | output | PAGE_BITS+1 | Segment byte count |
| seg_last | output | 1 | Final segment of message |
| seg_paddr | output | PA_W | Physical source address of segment |
| rx_valid | input | 1 | Received segment header present |
| rx_ready | output | 1 | Receive header accepted this cycle when high |
| rx_id | input | ID_W | Message id of received segment |
| rx_idx | input | IDX_W | Segment index (0 starts a message) |
| rx_len | input | PAGE_BITS+1 | Segment byte count |
| rx_last | input | 1 | Final segment of message |
| rx_base | input | VA_W | Destination virtual base, used when rx_idx is 0 |
| rx_near_full | input | 1 | Receive FIFO nearly full |
| wr_valid | output | 1 | Destination write pulse |
| wr_paddr | output | PA_W | Physical destination address |
| wr_len | output | PAGE_BITS+1 | Bytes in this write |
| xl_vpn | output | VA_W-PAGE_BITS | Virtual page looked up |
| xl_hit | input | 1 | Lookup found a mapping |
| xl_ppn | input | PA_W-PAGE_BITS | Physical page returned |
| done_valid | output | 1 | Completion pulse |
| done_rx | output | 1 | 1 for receive completion, 0 for send |
| done_id | output | ID_W | Completed message id |
| done_err | output | 1 | Message aborted by translation miss |

## Verification
The send path is swept over every in-page start offset, combined with lengths that are below, equal to, one above and several times the page size. This separates the short first segment from the full middle segments and from an exact final fit, and it also covers a zero-length message. The receive path is driven with source alignments that produce differently cut segments, landing at every destination offset. This shows whether pieces are split on destination pages rather than source pages. Misses placed mid-message on both sides show that the abort stops at the right byte and leaves the following message intact. Stalled-send and near-full runs with concurrent traffic show the dispatcher's drain behaviour and its rotation.

// File: rtl/msd_pkg.sv
package msd_pkg;
    typedef enum logic [1:0] {
        CL_RX  = 2'd0,
        CL_SND = 2'd1,
        CL_DN  = 2'd2
    } cls_e;
    localparam int NCLS = 3;
endpackage

// File: rtl/msd_arb.sv
module msd_arb
    import msd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] req,
    input  logic            urgent,
    output logic [NCLS-1:0] gnt
);
    typedef struct packed {
        logic [1:0] last;
    } arb_t;

    arb_t q, d;

    always_comb begin
        int cand;
        d    = q;
        gnt  = '0;
        cand = 0;
        if (urgent && req[CL_RX]) begin
            gnt[CL_RX] = 1'b1;
        end else begin
            for (int k = 1; k <= NCLS; k++) begin
                cand = (int'(q.last) + k) % NCLS;
                if (gnt == '0 && req[cand]) gnt[cand] = 1'b1;
            end
        end
        for (int i = 0; i < NCLS; i++) begin
            if (gnt[i]) d.last = 2'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.last <= 2'(CL_DN);
        else        q <= d;
    end
endmodule

// File: rtl/msd_chunk.sv
module msd_chunk #(
    parameter int PAGE_BITS = 13,
    parameter int REM_W     = 16
) (
    input  logic [PAGE_BITS-1:0] off,
    input  logic [REM_W-1:0]     rem,
    output logic [PAGE_BITS:0]   len,
    output logic                 fits
);
    localparam int PAGE = 1 << PAGE_BITS;
    localparam int CW   = (REM_W > PAGE_BITS + 1) ? REM_W : PAGE_BITS + 1;

    logic [CW-1:0] room_w, rem_w;

    always_comb begin
        room_w = CW'(PAGE) - CW'(off);
        rem_w  = CW'(rem);
        fits   = (rem_w <= room_w);
        len    = fits ? (PAGE_BITS+1)'(rem_w) : (PAGE_BITS+1)'(room_w);
    end
endmodule

// File: rtl/msd_top.sv
module msd_top
    import msd_pkg::*;
#(
    parameter int PAGE_BITS = 13,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int LEN_W     = 20,
    parameter int ID_W      = 6,
    parameter int IDX_W     = 8,
    localparam int SL_W     = PAGE_BITS + 1,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snd_valid,
    output logic             snd_ready,
    input  logic [ID_W-1:0]  snd_id,
    input  logic [VA_W-1:0]  snd_va,
    input  logic [LEN_W-1:0] snd_len,
    input  logic             seg_ready,
    output logic             seg_valid,
    output logic [ID_W-1:0]  seg_id,
    output logic [IDX_W-1:0] seg_idx,
    output logic [SL_W-1:0]  seg_len,
    output logic             seg_last,
    output logic [PA_W-1:0]  seg_paddr,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [ID_W-1:0]  rx_id,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic [SL_W-1:0]  rx_len,
    input  logic             rx_last,
    input  logic [VA_W-1:0]  rx_base,
    input  logic             rx_near_full,
    output logic             wr_valid,
    output logic [PA_W-1:0]  wr_paddr,
    output logic [SL_W-1:0]  wr_len,
    output logic [VPN_W-1:0] xl_vpn,
    input  logic             xl_hit,
    input  logic [PPN_W-1:0] xl_ppn,
    output logic             done_valid,
    output logic             done_rx,
    output logic [ID_W-1:0]  done_id,
    output logic             done_err
);
    typedef struct packed {
        // send context
        logic             s_act;
        logic             s_dn;
        logic             s_err;
        logic [ID_W-1:0]  s_id;
        logic [VA_W-1:0]  s_va;
        logic [LEN_W-1:0] s_rem;
        logic [IDX_W-1:0] s_idx;
        // receive context
        logic             r_full;
        logic             r_dn;
        logic             r_err;
        logic             r_bad;
        logic             r_last;
        logic [ID_W-1:0]  r_id;
        logic [VA_W-1:0]  r_va;
        logic [SL_W-1:0]  r_rem;
        // registered outputs
        logic             seg_v;
        logic [ID_W-1:0]  seg_id;
        logic [IDX_W-1:0] seg_idx;
        logic [SL_W-1:0]  seg_len;
        logic             seg_last;
        logic [PA_W-1:0]  seg_pa;
        logic             wr_v;
        logic [PA_W-1:0]  wr_pa;
        logic [SL_W-1:0]  wr_len;
        logic             dn_v;
        logic             dn_rx;
        logic [ID_W-1:0]  dn_id;
        logic             dn_err;
    } st_t;

    st_t q, d;

    logic [NCLS-1:0] req, gnt;
    logic [SL_W-1:0] s_chunk, r_chunk;
    logic            s_fit, r_fit;

    assign req[CL_RX]  = q.r_full;
    assign req[CL_SND] = q.s_act && seg_ready;
    assign req[CL_DN]  = q.s_dn || q.r_dn;

    msd_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .urgent(rx_near_full),
        .gnt   (gnt)
    );

    msd_chunk #(.PAGE_BITS(PAGE_BITS), .REM_W(LEN_W)) u_s_chunk (
        .off (q.s_va[PAGE_BITS-1:0]),
        .rem (q.s_rem),
        .len (s_chunk),
        .fits(s_fit)
    );

    msd_chunk #(.PAGE_BITS(PAGE_BITS), .REM_W(SL_W)) u_r_chunk (
        .off (q.r_va[PAGE_BITS-1:0]),
        .rem (q.r_rem),
        .len (r_chunk),
        .fits(r_fit)
    );

    assign xl_vpn    = gnt[CL_SND] ? q.s_va[VA_W-1:PAGE_BITS] : q.r_va[VA_W-1:PAGE_BITS];
    assign snd_ready = !q.s_act && !q.s_dn;
    assign rx_ready  = !q.r_full && !q.r_dn;

    always_comb begin
        d      = q;
        d.seg_v = 1'b0;
        d.wr_v  = 1'b0;
        d.dn_v  = 1'b0;

        // descriptor intake
        if (snd_valid && snd_ready) begin
            d.s_id  = snd_id;
            d.s_va  = snd_va;
            d.s_rem = snd_len;
            d.s_idx = '0;
            d.s_err = 1'b0;
            if (snd_len == '0) d.s_dn  = 1'b1;
            else               d.s_act = 1'b1;
        end
        if (rx_valid && rx_ready) begin
            d.r_full = 1'b1;
            d.r_id   = rx_id;
            d.r_last = rx_last;
            d.r_rem  = rx_len;
            if (rx_idx == '0) begin
                d.r_va  = rx_base;
                d.r_bad = 1'b0;
            end
        end

        // granted action
        if (gnt[CL_SND]) begin
            if (xl_hit) begin
                d.seg_v    = 1'b1;
                d.seg_id   = q.s_id;
                d.seg_idx  = q.s_idx;
                d.seg_len  = s_chunk;
                d.seg_last = s_fit;
                d.seg_pa   = {xl_ppn, q.s_va[PAGE_BITS-1:0]};
                d.s_va     = q.s_va + VA_W'(s_chunk);
                d.s_rem    = q.s_rem - LEN_W'(s_chunk);
                d.s_idx    = q.s_idx + 1'b1;
                if (s_fit) begin
                    d.s_act = 1'b0;
                    d.s_dn  = 1'b1;
                end
            end else begin
                d.s_act = 1'b0;
                d.s_dn  = 1'b1;
                d.s_err = 1'b1;
            end
        end else if (gnt[CL_RX]) begin
            if (q.r_bad || q.r_rem == '0) begin
                d.r_full = 1'b0;
                if (q.r_last) begin
                    d.r_dn  = 1'b1;
                    d.r_err = q.r_bad;
                end
            end else if (xl_hit) begin
                d.wr_v   = 1'b1;
                d.wr_pa  = {xl_ppn, q.r_va[PAGE_BITS-1:0]};
                d.wr_len = r_chunk;
                d.r_va   = q.r_va + VA_W'(r_chunk);
                d.r_rem  = q.r_rem - r_chunk;
                if (r_fit) begin
                    d.r_full = 1'b0;
                    if (q.r_last) begin
                        d.r_dn  = 1'b1;
                        d.r_err = 1'b0;
                    end
                end
            end else begin
                d.r_bad  = 1'b1;
                d.r_full = 1'b0;
                if (q.r_last) begin
                    d.r_dn  = 1'b1;
                    d.r_err = 1'b1;
                end
            end
        end else if (gnt[CL_DN]) begin
            d.dn_v = 1'b1;
            if (q.r_dn) begin
                d.dn_rx  = 1'b1;
                d.dn_id  = q.r_id;
                d.dn_err = q.r_err;
                d.r_dn   = 1'b0;
            end else begin
                d.dn_rx  = 1'b0;
                d.dn_id  = q.s_id;
                d.dn_err = q.s_err;
                d.s_dn   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign seg_valid  = q.seg_v;
    assign seg_id     = q.seg_id;
    assign seg_idx    = q.seg_idx;
    assign seg_len    = q.seg_len;
    assign seg_last   = q.seg_last;
    assign seg_paddr  = q.seg_pa;
    assign wr_valid   = q.wr_v;
    assign wr_paddr   = q.wr_pa;
    assign wr_len     = q.wr_len;
    assign done_valid = q.dn_v;
    assign done_rx    = q.dn_rx;
    assign done_id    = q.dn_id;
    assign done_err   = q.dn_err;
endmodule

// File: rtl/msd_chk.sv
module msd_chk #(
    parameter int PAGE_BITS = 13,
    parameter int PA_W      = 32,
    localparam int SL_W     = PAGE_BITS + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            snd_ready,
    input logic            seg_ready,
    input logic            seg_valid,
    input logic            seg_last,
    input logic [SL_W-1:0] seg_len,
    input logic [PA_W-1:0] seg_paddr,
    input logic            wr_valid,
    input logic [SL_W-1:0] wr_len,
    input logic [PA_W-1:0] wr_paddr,
    input logic            done_valid
);
    localparam int PAGE = 1 << PAGE_BITS;

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({seg_valid, wr_valid, done_valid}) <= 1); // R11

    AST_SEG_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0) &&
        (32'(seg_paddr[PAGE_BITS-1:0]) + 32'(seg_len) <= 32'(PAGE))); // R2

    AST_WR_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_len != '0) &&
        (32'(wr_paddr[PAGE_BITS-1:0]) + 32'(wr_len) <= 32'(PAGE))); // R6

    AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_ready |=> !seg_valid); // R9

    AST_ONE_SEND_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_last) |-> !snd_ready); // R12
endmodule

bind msd_top msd_chk #(.PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .snd_ready (snd_ready),
    .seg_ready (seg_ready),
    .seg_valid (seg_valid),
    .seg_last  (seg_last),
    .seg_len   (seg_len),
    .seg_paddr (seg_paddr),
    .wr_valid  (wr_valid),
    .wr_len    (wr_len),
    .wr_paddr  (wr_paddr),
    .done_valid(done_valid)
);

// File: tb/msd_top_bench.sv
module msd_top_bench;
    localparam int PB = 4;
    localparam int PG = 1 << PB;
    localparam int MISS_VPN = 8'hEE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snd_valid = 1'b0;
    logic       snd_ready;
    logic [3:0] snd_id = '0;
    logic [11:0] snd_va = '0;
    logic [7:0] snd_len = '0;
    logic       seg_ready = 1'b1;
    logic       seg_valid;
    logic [3:0] seg_id;
    logic [5:0] seg_idx;
    logic [4:0] seg_len;
    logic       seg_last;
    logic [11:0] seg_paddr;
    logic       rx_valid = 1'b0;
    logic       rx_ready;
    logic [3:0] rx_id = '0;
    logic [5:0] rx_idx = '0;
    logic [4:0] rx_len = '0;
    logic       rx_last = 1'b0;
    logic [11:0] rx_base = '0;
    logic       rx_near_full = 1'b0;
    logic       wr_valid;
    logic [11:0] wr_paddr;
    logic [4:0] wr_len;
    logic [7:0] xl_vpn;
    logic       xl_hit;
    logic [7:0] xl_ppn;
    logic       done_valid, done_rx, done_err;
    logic [3:0] done_id;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;
    int wr_n = 0;
    int seg_cnt = 0;
    int wr_cyc [0:1023];
    int rxs_len [0:31];
    int rxs_n = 0;

    always #4 clk = ~clk;

    assign xl_hit = (xl_vpn != 8'(MISS_VPN));
    assign xl_ppn = xl_vpn ^ 8'hA5;

    msd_top #(.PAGE_BITS(PB), .VA_W(12), .PA_W(12), .LEN_W(8), .ID_W(4), .IDX_W(6)) u_msd_top (
        .clk(clk), .rst_n(rst_n),
        .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_id(snd_id), .snd_va(snd_va), .snd_len(snd_len),
        .seg_ready(seg_ready), .seg_valid(seg_valid), .seg_id(seg_id), .seg_idx(seg_idx),
        .seg_len(seg_len), .seg_last(seg_last), .seg_paddr(seg_paddr),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_id(rx_id), .rx_idx(rx_idx), .rx_len(rx_len),
        .rx_last(rx_last), .rx_base(rx_base), .rx_near_full(rx_near_full),
        .wr_valid(wr_valid), .wr_paddr(wr_paddr), .wr_len(wr_len),
        .xl_vpn(xl_vpn), .xl_hit(xl_hit), .xl_ppn(xl_ppn),
        .done_valid(done_valid), .done_rx(done_rx), .done_id(done_id), .done_err(done_err)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (wr_valid) begin
            wr_cyc[wr_n % 1024] = cyc;
            wr_n = wr_n + 1;
        end
        if (seg_valid) seg_cnt = seg_cnt + 1;
    end

    function automatic int pa_of(input int va);
        return ((((va >> PB) & 255) ^ 8'hA5) << PB) | (va & (PG - 1));
    endfunction

    function automatic int piece(input int va, input int rem);
        int room = PG - (va % PG);
        return (rem < room) ? rem : room;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_start(input int id, input int va, input int len);
        snd_id = 4'(id); snd_va = 12'(va); snd_len = 8'(len); snd_valid = 1'b1;
        while (!snd_ready) @(negedge clk);
        @(negedge clk);
        snd_valid = 1'b0;
    endtask

    task automatic send_expect(input int id, input int va, input int len);
        int cur = va;
        int rem = len;
        int k = 0;
        bit miss = 1'b0;
        bit got;
        while (rem > 0 && !miss) begin
            int c = piece(cur, rem);
            if (((cur >> PB) & 255) == MISS_VPN) begin
                miss = 1'b1;
            end else begin
                got = 1'b0;
                for (int t = 0; t < 300 && !got; t++) begin
                    @(negedge clk);
                    if (seg_valid) got = 1'b1;
                end
                chk(got, "R2 segment arrives", int'(got), 1);
                if (got) begin
                    chk(seg_id == 4'(id), "R2 segment id", int'(seg_id), id);
                    chk(int'(seg_idx) == k, "R2 segment index", int'(seg_idx), k);
                    chk(int'(seg_len) == c, "R2 segment length", int'(seg_len), c);
                    chk(seg_last == (c == rem), "R2 last flag", int'(seg_last), int'(c == rem));
                    chk(int'(seg_paddr) == pa_of(cur), "R3 segment paddr", int'(seg_paddr), pa_of(cur));
                end
                cur += c; rem -= c; k++;
            end
        end
        got = 1'b0;
        for (int t = 0; t < 300 && !got; t++) begin
            @(negedge clk);
            if (seg_valid) chk(1'b0, "R5 no segment after end or miss", 1, 0);
            if (done_valid && !done_rx) got = 1'b1;
        end
        chk(got, miss ? "R5 send completion" : "R4 send completion", int'(got), 1);
        if (got) begin
            chk(done_id == 4'(id), "R4 done id", int'(done_id), id);
            chk(done_err == miss, miss ? "R5 error flag" : "R4 error flag", int'(done_err), int'(miss));
        end
    endtask

    task automatic build_rx(input int src_off, input int len);
        int cur = src_off;
        int rem = len;
        rxs_n = 0;
        while (rem > 0) begin
            int c = piece(cur, rem);
            rxs_len[rxs_n] = c;
            rxs_n++;
            cur += c; rem -= c;
        end
    endtask

    task automatic rx_run(input int id, input int base);
        fork
            begin
                for (int i = 0; i < rxs_n; i++) begin
                    rx_id = 4'(id); rx_idx = 6'(i); rx_len = 5'(rxs_len[i]);
                    rx_last = (i == rxs_n - 1); rx_base = 12'(base); rx_valid = 1'b1;
                    while (!rx_ready) @(negedge clk);
                    @(negedge clk);
                end
                rx_valid = 1'b0;
            end
            begin
                int cur = base;
                bit bad = 1'b0;
                bit got;
                for (int i = 0; i < rxs_n && !bad; i++) begin
                    int rem = rxs_len[i];
                    while (rem > 0 && !bad) begin
                        int c = piece(cur, rem);
                        if (((cur >> PB) & 255) == MISS_VPN) begin
                            bad = 1'b1;
                        end else begin
                            got = 1'b0;
                            for (int t = 0; t < 300 && !got; t++) begin
                                @(negedge clk);
                                if (wr_valid) got = 1'b1;
                            end
                            chk(got, "R6 write arrives", int'(got), 1);
                            if (got) begin
                                chk(int'(wr_paddr) == pa_of(cur), "R6 write paddr", int'(wr_paddr), pa_of(cur));
                                chk(int'(wr_len) == c, "R6 write length", int'(wr_len), c);
                            end
                            cur += c; rem -= c;
                        end
                    end
                end
                got = 1'b0;
                for (int t = 0; t < 300 && !got; t++) begin
                    @(negedge clk);
                    if (wr_valid) chk(1'b0, "R8 no write after end or miss", 1, 0);
                    if (done_valid && done_rx) got = 1'b1;
                end
                chk(got, bad ? "R8 receive completion" : "R7 receive completion", int'(got), 1);
                if (got) begin
                    chk(done_id == 4'(id), "R7 done id", int'(done_id), id);
                    chk(done_err == bad, bad ? "R8 error flag" : "R7 error flag", int'(done_err), int'(bad));
                end
            end
        join
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        finish_run();
    end

    initial begin
        int id = 0;
        int lens [6] = '{1, 15, 16, 17, 40, 100};
        int mark;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!seg_valid && !wr_valid && !done_valid, "R1 outputs idle", int'(seg_valid | wr_valid | done_valid), 0);
        chk(snd_ready && rx_ready, "R1 ready high", int'(snd_ready & rx_ready), 1);

        // R2 R3 R4 send sweep: every offset x length
        for (int off = 0; off < PG; off++) begin
            foreach (lens[j]) begin
                send_start(id, 12'h100 + off, lens[j]);
                send_expect(id, 12'h100 + off, lens[j]);
                id = (id + 1) % 16;
            end
        end
        // R4 zero length
        send_start(7, 12'h123, 0);
        send_expect(7, 12'h123, 0);
        // R5 send miss on second page, then a clean message
        send_start(9, 12'hED8, 40);
        send_expect(9, 12'hED8, 40);
        send_start(10, 12'h208, 40);
        send_expect(10, 12'h208, 40);

        // R6 R7 receive sweep: two source alignments x every destination offset
        for (int s = 0; s < 2; s++) begin
            for (int doff = 0; doff < PG; doff++) begin
                build_rx(s * 5, 37);
                rx_run(id, 12'h300 + doff);
                id = (id + 1) % 16;
            end
        end
        // R8 receive miss mid-message, then the next message intact
        build_rx(0, 48);
        rx_run(11, 12'hED4);
        build_rx(3, 30);
        rx_run(12, 12'h20A);

        // R9 send stalled, receive drains
        seg_ready = 1'b0;
        mark = seg_cnt;
        send_start(3, 12'h300, 50);
        build_rx(2, 40);
        rx_run(4, 12'h40C);
        repeat (3) @(negedge clk);
        chk(seg_cnt == mark, "R9 no segment while stalled", seg_cnt - mark, 0);
        seg_ready = 1'b1;
        send_expect(3, 12'h300, 50);

        // R10 near full: held segment served back to back
        rx_near_full = 1'b1;
        build_rx(0, 16);
        mark = wr_n;
        fork
            begin send_start(5, 12'h400, 200); send_expect(5, 12'h400, 200); end
            begin repeat (2) @(negedge clk); rx_run(6, 12'h508); end
        join
        chk(wr_n - mark == 2, "R10 piece count", wr_n - mark, 2);
        chk(wr_cyc[(mark + 1) % 1024] - wr_cyc[mark % 1024] == 1, "R10 back-to-back pieces",
            wr_cyc[(mark + 1) % 1024] - wr_cyc[mark % 1024], 1);
        rx_near_full = 1'b0;

        // R13 rotation without near full
        mark = wr_n;
        fork
            begin send_start(8, 12'h400, 200); send_expect(8, 12'h400, 200); end
            begin repeat (2) @(negedge clk); rx_run(13, 12'h508); end
        join
        chk(wr_n - mark == 2, "R13 piece count", wr_n - mark, 2);
        chk(wr_cyc[(mark + 1) % 1024] - wr_cyc[mark % 1024] == 2, "R13 rotated pieces",
            wr_cyc[(mark + 1) % 1024] - wr_cyc[mark % 1024], 2);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule